// File: doc/BRIEF.md
# Lane Transmit Equalization Update Sequencer

This block reprograms the transmit equalization setting of one serial lane without software having to pace the register accesses itself. Software presents three tap coefficients (pre-cursor, post-cursor and main tap) and a flag that asks for the lane to be held in reset during the update, then pulses start. The block latches these inputs and builds a 32-bit equalization word from a fixed base pattern and the shifted coefficient fields. It then issues register accesses on a simple single-cycle bus toward the lane's control register bank.

When the reset hold is requested, the block first clears the lane-reset field of the general control register with a read-modify-write. It then writes the equalization word and finally sets the reset field again with a second read-modify-write. A programmable idle time of one microsecond follows every write. Without the reset hold, only the equalization write and its idle time take place. A one-cycle done pulse marks the end of the update.

The bus has no handshake. An access completes in the cycle in which it is presented. Read data is taken combinationally from the bank in that same cycle.

Top module: `lane_txeq_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `bus_en_o` are all 0, and no bus access is made while the block is idle.
- R2: The equalization word is 0x24200000 OR (pre masked to its low 4 bits, shifted left by 22) OR (post masked to its low 5 bits, shifted left by 16) OR (main masked to its low 6 bits, shifted left by 8). Coefficient bits above those widths have no effect on the word.
- R3: With `hold_rst_i`=1, exactly three writes occur, in this order: general control (offset 0x00), equalization (offset 0x18), general control (offset 0x00).
- R4: The lane-reset field is bits 22:21 of the general control register. The first write carries the value read just before it with bits 22:21 cleared. The last write carries a fresh read of the register with bits 22:21 set. All other bits are kept, including changes made to the register while the sequence is running.
- R5: With `hold_rst_i`=0, exactly one write occurs, and it goes to the equalization register at offset 0x18.
- R6: After each write, the block makes no bus access for `CYC_PER_US` cycles. Between successive writes the gap is therefore `CYC_PER_US`+1 cycles, or `CYC_PER_US`+2 cycles when a read precedes the second write. `done_o` comes `CYC_PER_US`+1 cycles after the last write.
- R7: `done_o` is high for exactly one cycle per accepted start, and `busy_o` is 0 in the cycle after it.
- R8: A start pulse that arrives while `busy_o` is 1 is ignored. It causes no extra access and no extra done, and it does not change the word that is written.
- R9: Bus addresses are byte offsets within a 64-byte lane window. Only offsets 0x00 and 0x18 are ever driven while `bus_en_o` is 1.
- R10: The coefficients and the reset flag are captured on the accepted start. Changing them afterwards does not alter the sequence in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| hold_rst_i | input | 1 | Hold the lane in reset around the update |
| pre_i | input | 6 | Pre-cursor coefficient |
| post_i | input | 6 | Post-cursor coefficient |
| main_i | input | 6 | Main tap coefficient |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| bus_en_o | output | 1 | Bus access this cycle |
| bus_wr_o | output | 1 | Access is a write (0 = read) |
| bus_addr_o | output | 6 | Byte offset within the lane window |
| bus_wdata_o | output | 32 | Write data |
| bus_rdata_i | input | 32 | Read data, valid in the cycle of a read |

## Verification
The word builder is driven with all-zero coefficients, with coefficients that have their upper bits set, and with mixed values. These patterns separate a correct field placement from a wrong shift, a missing mask, or a base constant that overlaps a field. The sequence is run with and without the reset hold to tell the three-write order from the single-write path. It is also run with a general control value full of unrelated set bits, and with a bit flipped by the bench during the middle wait. These two runs show that both read-modify-writes keep the other bits and that the release re-reads the register. A second start during a running update and coefficient changes after start show that only the first accepted request shapes the bus traffic.

// File: rtl/lane_txeq_pkg.sv
package lane_txeq_pkg;

    localparam int DATA_W    = 32;
    localparam int WIN_BYTES = 64;
    localparam int ADDR_W    = $clog2(WIN_BYTES);
    localparam int COEF_W    = 6;

    localparam logic [DATA_W-1:0] EQ_BASE   = 32'h2420_0000;
    localparam int                PRE_SHIFT  = 22;
    localparam int                POST_SHIFT = 16;
    localparam int                MAIN_SHIFT = 8;

    localparam int RST_LO = 21;
    localparam int RST_HI = 22;
    localparam logic [DATA_W-1:0] RST_FIELD =
        ((DATA_W'(1) << (RST_HI - RST_LO + 1)) - DATA_W'(1)) << RST_LO;

    localparam logic [ADDR_W-1:0] OFS_GCTL = ADDR_W'(8'h00);
    localparam logic [ADDR_W-1:0] OFS_TXEQ = ADDR_W'(8'h18);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_HOLD,
        ST_WR_HOLD,
        ST_WT_HOLD,
        ST_WR_EQ,
        ST_WT_EQ,
        ST_RD_FREE,
        ST_WR_FREE,
        ST_WT_FREE,
        ST_FINISH
    } seq_state_e;

    typedef struct packed {
        seq_state_e        state;
        logic              hold;
        logic [DATA_W-1:0] word;
        logic [DATA_W-1:0] snap;
    } seq_regs_t;

endpackage

// File: rtl/lane_txeq_word.sv
module lane_txeq_word
    import lane_txeq_pkg::*;
#(
    parameter int PRE_W  = 4,
    parameter int POST_W = 5,
    parameter int MAIN_W = 6
) (
    input  logic [COEF_W-1:0] pre_i,
    input  logic [COEF_W-1:0] post_i,
    input  logic [COEF_W-1:0] main_i,
    output logic [DATA_W-1:0] word_o
);

    localparam logic [COEF_W-1:0] PRE_MASK  = COEF_W'((1 << PRE_W) - 1);
    localparam logic [COEF_W-1:0] POST_MASK = COEF_W'((1 << POST_W) - 1);
    localparam logic [COEF_W-1:0] MAIN_MASK = COEF_W'((1 << MAIN_W) - 1);

    logic [DATA_W-1:0] pre_f, post_f, main_f;

    always_comb begin
        pre_f  = DATA_W'(pre_i  & PRE_MASK)  << PRE_SHIFT;
        post_f = DATA_W'(post_i & POST_MASK) << POST_SHIFT;
        main_f = DATA_W'(main_i & MAIN_MASK) << MAIN_SHIFT;
        word_o = EQ_BASE | pre_f | post_f | main_f;
    end

endmodule

// File: rtl/lane_txeq_timer.sv
module lane_txeq_timer #(
    parameter int CYC_PER_US = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic expired_o
);

    localparam int CNT_W = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(CYC_PER_US - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = LOAD_VAL;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/lane_txeq_rmw.sv
module lane_txeq_rmw
    import lane_txeq_pkg::*;
(
    input  logic [DATA_W-1:0] old_i,
    input  logic              release_i,
    output logic [DATA_W-1:0] new_o
);

    always_comb begin
        if (release_i) begin
            new_o = old_i | RST_FIELD;
        end else begin
            new_o = old_i & ~RST_FIELD;
        end
    end

endmodule

// File: rtl/lane_txeq_seq.sv
module lane_txeq_seq
    import lane_txeq_pkg::*;
#(
    parameter int CYC_PER_US = 125,
    parameter int PRE_W      = 4,
    parameter int POST_W     = 5,
    parameter int MAIN_W     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              hold_rst_i,
    input  logic [5:0]        pre_i,
    input  logic [5:0]        post_i,
    input  logic [5:0]        main_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              bus_en_o,
    output logic              bus_wr_o,
    output logic [5:0]        bus_addr_o,
    output logic [31:0]       bus_wdata_o,
    input  logic [31:0]       bus_rdata_i
);

    seq_regs_t         r_d, r_q;
    logic [DATA_W-1:0] word_new;
    logic [DATA_W-1:0] rmw_val;
    logic              rmw_release;
    logic              tmr_load;
    logic              tmr_expired;

    lane_txeq_word #(
        .PRE_W  (PRE_W),
        .POST_W (POST_W),
        .MAIN_W (MAIN_W)
    ) i_word (
        .pre_i  (pre_i),
        .post_i (post_i),
        .main_i (main_i),
        .word_o (word_new)
    );

    lane_txeq_timer #(
        .CYC_PER_US (CYC_PER_US)
    ) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .expired_o (tmr_expired)
    );

    assign rmw_release = (r_q.state == ST_WR_FREE);

    lane_txeq_rmw i_rmw (
        .old_i     (r_q.snap),
        .release_i (rmw_release),
        .new_o     (rmw_val)
    );

    always_comb begin
        r_d         = r_q;
        tmr_load    = 1'b0;
        bus_en_o    = 1'b0;
        bus_wr_o    = 1'b0;
        bus_addr_o  = OFS_GCTL;
        bus_wdata_o = '0;
        done_o      = 1'b0;

        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.word  = word_new;
                    r_d.hold  = hold_rst_i;
                    r_d.state = hold_rst_i ? ST_RD_HOLD : ST_WR_EQ;
                end
            end
            ST_RD_HOLD: begin
                bus_en_o  = 1'b1;
                r_d.snap  = bus_rdata_i;
                r_d.state = ST_WR_HOLD;
            end
            ST_WR_HOLD: begin
                bus_en_o    = 1'b1;
                bus_wr_o    = 1'b1;
                bus_wdata_o = rmw_val;
                tmr_load    = 1'b1;
                r_d.state   = ST_WT_HOLD;
            end
            ST_WT_HOLD: begin
                if (tmr_expired) begin
                    r_d.state = ST_WR_EQ;
                end
            end
            ST_WR_EQ: begin
                bus_en_o    = 1'b1;
                bus_wr_o    = 1'b1;
                bus_addr_o  = OFS_TXEQ;
                bus_wdata_o = r_q.word;
                tmr_load    = 1'b1;
                r_d.state   = ST_WT_EQ;
            end
            ST_WT_EQ: begin
                if (tmr_expired) begin
                    r_d.state = r_q.hold ? ST_RD_FREE : ST_FINISH;
                end
            end
            ST_RD_FREE: begin
                bus_en_o  = 1'b1;
                r_d.snap  = bus_rdata_i;
                r_d.state = ST_WR_FREE;
            end
            ST_WR_FREE: begin
                bus_en_o    = 1'b1;
                bus_wr_o    = 1'b1;
                bus_wdata_o = rmw_val;
                tmr_load    = 1'b1;
                r_d.state   = ST_WT_FREE;
            end
            ST_WT_FREE: begin
                if (tmr_expired) begin
                    r_d.state = ST_FINISH;
                end
            end
            ST_FINISH: begin
                done_o    = 1'b1;
                r_d.state = ST_IDLE;
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, hold: 1'b0, word: '0, snap: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o = (r_q.state != ST_IDLE);

endmodule

// File: rtl/lane_txeq_seq_chk.sv
module lane_txeq_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        busy_o,
    input logic        done_o,
    input logic        bus_en_o,
    input logic        bus_wr_o,
    input logic [5:0]  bus_addr_o,
    input logic [31:0] bus_wdata_o
);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !bus_en_o);

    p_eq_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en_o && bus_wr_o && bus_addr_o == 6'h18)
            |-> ((bus_wdata_o & 32'h2420_0000) == 32'h2420_0000));

    p_rst_field_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en_o && bus_wr_o && bus_addr_o == 6'h00)
            |-> (bus_wdata_o[22:21] == 2'b00 || bus_wdata_o[22:21] == 2'b11));

    p_quiet_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en_o && bus_wr_o) |=> !bus_en_o);

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o && start_i) |=> busy_o);

    p_addr_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_en_o |-> (bus_addr_o == 6'h00 || bus_addr_o == 6'h18));

endmodule

bind lane_txeq_seq lane_txeq_seq_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .bus_en_o    (bus_en_o),
    .bus_wr_o    (bus_wr_o),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o)
);

// File: tb/test_lane_txeq_seq.sv
`timescale 1ns/1ps
module test_lane_txeq_seq;

    localparam int US = 125;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        hold_rst_i = 1'b0;
    logic [5:0]  pre_i = '0, post_i = '0, main_i = '0;
    logic        busy_o, done_o, bus_en_o, bus_wr_o;
    logic [5:0]  bus_addr_o;
    logic [31:0] bus_wdata_o, bus_rdata_i;

    always #4 clk = ~clk;

    lane_txeq_seq #(.CYC_PER_US(US)) i_lane_txeq_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .hold_rst_i(hold_rst_i),
        .pre_i(pre_i), .post_i(post_i), .main_i(main_i),
        .busy_o(busy_o), .done_o(done_o), .bus_en_o(bus_en_o),
        .bus_wr_o(bus_wr_o), .bus_addr_o(bus_addr_o),
        .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata_i)
    );

    // register bank model and bus monitor
    logic [31:0] m_gctl, m_txeq;
    int          cyc = 0;
    int          wr_n = 0, done_n = 0, done_cyc = 0, bad_addr = 0;
    logic [5:0]  wr_addr [8];
    logic [31:0] wr_data [8];
    int          wr_cyc  [8];
    logic        poke_en = 1'b0;

    assign bus_rdata_i = (bus_addr_o == 6'h00) ? m_gctl :
                         (bus_addr_o == 6'h18) ? m_txeq : 32'h0;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (bus_en_o && bus_addr_o != 6'h00 && bus_addr_o != 6'h18)
            bad_addr <= bad_addr + 1;
        if (bus_en_o && bus_wr_o) begin
            if (wr_n < 8) begin
                wr_addr[wr_n] <= bus_addr_o;
                wr_data[wr_n] <= bus_wdata_o;
                wr_cyc[wr_n]  <= cyc;
            end
            wr_n <= wr_n + 1;
            if (bus_addr_o == 6'h00) m_gctl <= bus_wdata_o;
            if (bus_addr_o == 6'h18) m_txeq <= bus_wdata_o;
        end else if (poke_en && wr_n == 2 && cyc == wr_cyc[1] + 3) begin
            m_gctl <= m_gctl ^ 32'h0000_0001;
        end
        if (done_o) begin
            done_n   <= done_n + 1;
            done_cyc <= cyc;
        end
    end

    int checks = 0, errors = 0;

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input logic [5:0] p, input logic [5:0] q,
                                             input logic [5:0] m);
        logic [31:0] w;
        w = 32'h2420_0000;
        w = w | ({28'd0, p[3:0]} << 22);
        w = w | ({27'd0, q[4:0]} << 16);
        w = w | ({26'd0, m[5:0]} << 8);
        return w;
    endfunction

    task automatic clear_log();
        @(negedge clk);
        wr_n = 0; done_n = 0; bad_addr = 0;
    endtask

    task automatic kick(input logic h, input logic [5:0] p, input logic [5:0] q,
                        input logic [5:0] m);
        @(negedge clk);
        start_i = 1'b1; hold_rst_i = h; pre_i = p; post_i = q; main_i = m;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (done_n == 0 && n < 2000) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset_state();
        chk(busy_o == 1'b0, "R1 busy after reset", 32'(busy_o), 0);
        chk(done_o == 1'b0, "R1 done after reset", 32'(done_o), 0);
        chk(bus_en_o == 1'b0, "R1 bus idle after reset", 32'(bus_en_o), 0);
        repeat (20) @(negedge clk);
        chk(wr_n == 0, "R1 no access while idle", wr_n, 0);
    endtask

    task automatic t_hold_seq(input logic [5:0] p, input logic [5:0] q,
                              input logic [5:0] m, input logic [31:0] g0,
                              input logic poke);
        logic [31:0] g_mid;
        m_gctl = g0;
        poke_en = poke;
        clear_log();
        kick(1'b1, p, q, m);
        // R10: change inputs during the running update
        pre_i = ~p; post_i = ~q; main_i = ~m; hold_rst_i = 1'b0;
        wait_done();
        poke_en = 1'b0;
        g_mid = poke ? (g0 & 32'hFF9F_FFFF) ^ 32'h1 : (g0 & 32'hFF9F_FFFF);
        chk(wr_n == 3, "R3 write count with hold", wr_n, 3);
        chk(wr_addr[0] == 6'h00 && wr_addr[1] == 6'h18 && wr_addr[2] == 6'h00,
            "R3 write order", {8'd0, 2'b0, wr_addr[0], 2'b0, wr_addr[1], 2'b0, wr_addr[2]},
            32'h0000_1800);
        chk(wr_data[0] == (g0 & 32'hFF9F_FFFF), "R4 assert keeps other bits",
            wr_data[0], g0 & 32'hFF9F_FFFF);
        chk(wr_data[1] == exp_word(p, q, m), "R2 R10 equalization word",
            wr_data[1], exp_word(p, q, m));
        chk(wr_data[2] == (g_mid | 32'h0060_0000), "R4 release re-reads register",
            wr_data[2], g_mid | 32'h0060_0000);
        chk(wr_cyc[1] - wr_cyc[0] == US + 1, "R6 gap assert to eq",
            wr_cyc[1] - wr_cyc[0], US + 1);
        chk(wr_cyc[2] - wr_cyc[1] == US + 2, "R6 gap eq to release",
            wr_cyc[2] - wr_cyc[1], US + 2);
        chk(done_cyc - wr_cyc[2] == US + 1, "R6 done after last wait",
            done_cyc - wr_cyc[2], US + 1);
        chk(done_n == 1 && busy_o == 1'b0, "R7 single done then idle",
            done_n, 1);
        chk(bad_addr == 0, "R9 only legal offsets", bad_addr, 0);
    endtask

    task automatic t_plain_seq(input logic [5:0] p, input logic [5:0] q,
                               input logic [5:0] m);
        logic [31:0] g_before;
        g_before = m_gctl;
        clear_log();
        kick(1'b0, p, q, m);
        wait_done();
        chk(wr_n == 1, "R5 single write without hold", wr_n, 1);
        chk(wr_addr[0] == 6'h18, "R5 R9 write goes to eq offset", 32'(wr_addr[0]), 32'h18);
        chk(wr_data[0] == exp_word(p, q, m), "R2 plain word", wr_data[0], exp_word(p, q, m));
        chk(m_gctl == g_before, "R5 general control untouched", m_gctl, g_before);
        chk(done_cyc - wr_cyc[0] == US + 1, "R6 plain done timing",
            done_cyc - wr_cyc[0], US + 1);
        chk(done_n == 1, "R7 plain done count", done_n, 1);
    endtask

    task automatic t_busy_start();
        m_gctl = 32'h0060_00F0;
        clear_log();
        kick(1'b1, 6'd3, 6'd7, 6'd11);
        repeat (10) @(negedge clk);
        kick(1'b0, 6'd15, 6'd31, 6'd63);
        repeat (US) @(negedge clk);
        kick(1'b0, 6'd1, 6'd1, 6'd1);
        wait_done();
        repeat (2 * US) @(negedge clk);
        chk(wr_n == 3, "R8 start while busy adds no write", wr_n, 3);
        chk(wr_data[1] == exp_word(6'd3, 6'd7, 6'd11), "R8 word from first start",
            wr_data[1], exp_word(6'd3, 6'd7, 6'd11));
        chk(done_n == 1, "R8 no extra done", done_n, 1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        m_gctl = 32'h0060_0000;
        m_txeq = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_hold_seq(6'd0, 6'd0, 6'd0, 32'h0060_0000, 1'b0);
        t_hold_seq(6'h3F, 6'h3F, 6'h3F, 32'hA5E5_A5A4, 1'b0);
        t_hold_seq(6'h15, 6'h2A, 6'h09, 32'h5A7F_5A5A, 1'b1);
        t_plain_seq(6'h0C, 6'h13, 6'h22);
        t_plain_seq(6'h30, 6'h20, 6'h01);
        t_busy_start();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule